// File: doc/BRIEF.md
# AUX Reply Status Classifier

This block sits behind an AUX channel receiver and turns the end of one transaction into a single verdict. After a `start` pulse it waits for the receiver to signal completion. While it waits, it watches a hot-plug loss flag and a watchdog counter. When the receiver finishes, the block reads the receiver's error flags and its reply byte count and decides the result. The result is success, timeout, invalid reply or disconnect.

On a successful transaction the block pulls the reply bytes from a ready/valid byte stream. The first byte carries the reply code in its upper four bits. When that code means acknowledge, the remaining bytes are written into a caller buffer through a simple write port, provided they fit within the caller's stated capacity. When they do not fit, an overflow flag is raised and nothing is written.

All results are registered and announced by a one-cycle `res_vld` strobe. Retrying, line decoding and request building belong to other blocks.

Top module: `aux_reply_classifier`

## Requirements
- R1: After reset, `res_vld`, `res_code`, `reply_code`, `data_cnt`, `overflow`, `buf_we` and `byte_rdy` are all 0.
- R2: While waiting, a high `hpd_lost` ends the wait with `res_code` = 3 (disconnect), regardless of `rx_done` or any flag.
- R3: When `rx_done` is seen without disconnect, and `rx_flags[0]` (receive timeout) or `rx_flags[1]` (timeout state) is set, `res_code` = 1 (timeout).
- R4: Otherwise, if any of `rx_flags[2]` (bad stop), `rx_flags[3]` (no detect), `rx_flags[4]` (bad high) or `rx_flags[5]` (bad low) is set, `res_code` = 2 (invalid reply).
- R5: `rx_flags[6]` (minimum-count debug flag) has no effect on any output.
- R6: With clean flags, an `rx_count` of 0 gives `res_code` = 2. Any other count gives `res_code` = 0 (success) and `data_cnt` = `rx_count` - 1. On non-success results, `data_cnt` is 0.
- R7: On success, `reply_code` equals bits [7:4] of the first byte taken from the stream. A value of 0 means acknowledge. On other results, `reply_code` is 0.
- R8: Only when `reply_code` is 0, and no overflow occurs, are the `data_cnt` bytes that follow the first byte written in order to `buf_addr` 0, 1, …; otherwise `buf_we` never rises.
- R9: On acknowledge with `data_cnt` > `buf_size`, `overflow` = 1, `res_code` stays 0, and no byte is written.
- R10: If neither `rx_done` nor `hpd_lost` arrives within `TMO_CYC` cycles of waiting, `res_code` = 1. Completion on the last allowed cycle still wins.
- R11: `res_vld` is high for exactly one cycle per accepted `start`, and the result outputs hold their values until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin waiting for a transaction result (accepted when idle) |
| rx_done | input | 1 | Receiver completion indication |
| hpd_lost | input | 1 | Hot-plug loss indication |
| rx_flags | input | 7 | Receiver error flags, bit map as in R3 to R5 |
| rx_count | input | CNT_W | Number of reply bytes, including the status byte |
| buf_size | input | CNT_W | Caller buffer capacity in bytes |
| byte_vld | input | 1 | Reply byte stream valid |
| byte_in | input | 8 | Reply byte stream data |
| byte_rdy | output | 1 | Block is taking reply bytes |
| buf_we | output | 1 | Caller buffer write strobe |
| buf_addr | output | CNT_W | Caller buffer write address |
| buf_wdata | output | 8 | Caller buffer write data |
| res_vld | output | 1 | One-cycle result strobe |
| res_code | output | 2 | 0 success, 1 timeout, 2 invalid reply, 3 disconnect |
| reply_code | output | 4 | Upper nibble of the first reply byte |
| data_cnt | output | CNT_W | Data bytes in the reply (count minus one) |
| overflow | output | 1 | Acknowledged data did not fit the caller buffer |

## Verification
A wrong priority between the flag groups shows up as a wrong `res_code` in the cycle right after the strobe. A sweep over all 128 flag patterns therefore exposes it at once. A stuck or miscounted watchdog shifts the timeout result by one or more cycles against the completion delay, which is swept across the limit. A bad byte index or a missed acknowledge check appears as extra, missing or misplaced buffer writes, which are compared byte by byte one cycle after the strobe.

// File: rtl/aux_reply_classifier.sv
module aux_reply_classifier #(
  parameter int CNT_W   = 5,
  parameter int TMO_CYC = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rx_done,
  input  logic             hpd_lost,
  input  logic [6:0]       rx_flags,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] buf_size,
  input  logic             byte_vld,
  input  logic [7:0]       byte_in,
  output logic             byte_rdy,
  output logic             buf_we,
  output logic [CNT_W-1:0] buf_addr,
  output logic [7:0]       buf_wdata,
  output logic             res_vld,
  output logic [1:0]       res_code,
  output logic [3:0]       reply_code,
  output logic [CNT_W-1:0] data_cnt,
  output logic             overflow
);
  localparam int TW = $clog2(TMO_CYC + 1);
  localparam logic [1:0] S_IDLE = 2'd0, S_WAIT = 2'd1, S_HEAD = 2'd2, S_DATA = 2'd3;
  localparam logic [1:0] C_OK = 2'd0, C_TMO = 2'd1, C_BAD = 2'd2, C_DISC = 2'd3;

  logic [1:0]       st;
  logic [TW-1:0]    wd;
  logic [CNT_W-1:0] idx;

  wire tmo_hit = |rx_flags[1:0];
  wire bad_hit = |rx_flags[5:2];
  wire wd_last = (wd == TW'(TMO_CYC - 1));
  wire take    = byte_rdy & byte_vld;

  assign byte_rdy = (st == S_HEAD) || (st == S_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      wd         <= '0;
      idx        <= '0;
      buf_we     <= 1'b0;
      buf_addr   <= '0;
      buf_wdata  <= '0;
      res_vld    <= 1'b0;
      res_code   <= C_OK;
      reply_code <= '0;
      data_cnt   <= '0;
      overflow   <= 1'b0;
    end else begin
      res_vld <= 1'b0;
      buf_we  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st         <= S_WAIT;
          wd         <= '0;
          res_code   <= C_OK;
          reply_code <= '0;
          data_cnt   <= '0;
          overflow   <= 1'b0;
        end
        S_WAIT: begin
          wd <= wd + 1'b1;
          if (hpd_lost) begin
            res_code <= C_DISC;
            res_vld  <= 1'b1;
            st       <= S_IDLE;
          end else if (rx_done) begin
            if (tmo_hit) begin
              res_code <= C_TMO;
              res_vld  <= 1'b1;
              st       <= S_IDLE;
            end else if (bad_hit || rx_count == '0) begin
              res_code <= C_BAD;
              res_vld  <= 1'b1;
              st       <= S_IDLE;
            end else begin
              data_cnt <= rx_count - 1'b1;
              st       <= S_HEAD;
            end
          end else if (wd_last) begin
            res_code <= C_TMO;
            res_vld  <= 1'b1;
            st       <= S_IDLE;
          end
        end
        S_HEAD: if (take) begin
          reply_code <= byte_in[7:4];
          idx        <= '0;
          if (byte_in[7:4] != 4'd0 || data_cnt == '0) begin
            res_vld <= 1'b1;
            st      <= S_IDLE;
          end else if (data_cnt > buf_size) begin
            overflow <= 1'b1;
            res_vld  <= 1'b1;
            st       <= S_IDLE;
          end else begin
            st <= S_DATA;
          end
        end
        default: if (take) begin
          buf_we    <= 1'b1;
          buf_addr  <= idx;
          buf_wdata <= byte_in;
          idx       <= idx + 1'b1;
          if (idx == data_cnt - 1'b1) begin
            res_vld <= 1'b1;
            st      <= S_IDLE;
          end
        end
      endcase
    end
  end
endmodule

module aux_reply_classifier_chk #(
  parameter int CNT_W   = 5,
  parameter int TMO_CYC = 1000,
  parameter int TW      = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       st,
  input logic [TW-1:0]    wd,
  input logic             rx_done,
  input logic             hpd_lost,
  input logic [6:0]       rx_flags,
  input logic [CNT_W-1:0] rx_count,
  input logic             res_vld,
  input logic [1:0]       res_code,
  input logic [3:0]       reply_code,
  input logic             buf_we,
  input logic             overflow
);
  wire waiting = (st == 2'd1);
  wire clean   = waiting && !hpd_lost && rx_done;

  p_disc_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && hpd_lost) |=> (res_vld && res_code == 2'd3));
  p_tmo_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clean && |rx_flags[1:0]) |=> (res_vld && res_code == 2'd1));
  p_bad_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clean && rx_flags[1:0] == 2'b00 && |rx_flags[5:2]) |=> (res_vld && res_code == 2'd2));
  p_dbg_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clean && rx_flags[5:0] == 6'd0 && rx_flags[6] && rx_count != '0) |=> !res_vld);
  p_zero_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clean && rx_flags[5:0] == 6'd0 && rx_count == '0) |=> (res_vld && res_code == 2'd2));
  p_ack_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (reply_code == 4'd0 && !overflow));
  p_ovf_success_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (res_code == 2'd0 && !buf_we));
  p_watchdog_r10: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> (int'(wd) < TMO_CYC));
  p_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |=> !res_vld);
endmodule

bind aux_reply_classifier aux_reply_classifier_chk #(
  .CNT_W(CNT_W), .TMO_CYC(TMO_CYC), .TW(TW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .wd(wd), .rx_done(rx_done),
  .hpd_lost(hpd_lost), .rx_flags(rx_flags), .rx_count(rx_count),
  .res_vld(res_vld), .res_code(res_code), .reply_code(reply_code),
  .buf_we(buf_we), .overflow(overflow)
);

// File: tb/sim_aux_reply_classifier.sv
module sim_aux_reply_classifier;
  localparam int CW  = 5;
  localparam int TMO = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, rx_done = 0, hpd_lost = 0, byte_vld = 0;
  logic [6:0] rx_flags = '0;
  logic [CW-1:0] rx_count = '0, buf_size = '0;
  logic [7:0] byte_in;
  logic byte_rdy, buf_we, res_vld, overflow;
  logic [CW-1:0] buf_addr, data_cnt;
  logic [7:0] buf_wdata;
  logic [1:0] res_code;
  logic [3:0] reply_code;

  always #2 clk = ~clk;

  aux_reply_classifier #(.CNT_W(CW), .TMO_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .rx_done(rx_done), .hpd_lost(hpd_lost),
    .rx_flags(rx_flags), .rx_count(rx_count), .buf_size(buf_size), .byte_vld(byte_vld),
    .byte_in(byte_in), .byte_rdy(byte_rdy), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .res_vld(res_vld), .res_code(res_code), .reply_code(reply_code),
    .data_cnt(data_cnt), .overflow(overflow));

  integer total = 0, bad = 0;
  logic clr = 0;
  logic [7:0] seed = 0;
  logic [3:0] rcode = 0;
  logic [7:0] bidx;
  integer wcnt;
  logic [7:0] mem [0:31];

  function automatic logic [7:0] pat(input logic [7:0] s, input logic [7:0] i);
    return s ^ (i * 8'd29);
  endfunction

  assign byte_in = (bidx == 8'd0) ? {rcode, seed[3:0]} : pat(seed, bidx);

  always @(posedge clk) begin
    if (clr) begin
      bidx <= 0;
      wcnt <= 0;
    end else begin
      if (byte_rdy && byte_vld) bidx <= bidx + 1;
      if (buf_we) begin
        mem[buf_addr] <= buf_wdata;
        wcnt <= wcnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input integer act, input integer exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input logic [6:0] fl, input bit dn, input bit dc, input int d,
                     input logic [CW-1:0] cnt, input logic [3:0] rc,
                     input logic [CW-1:0] bsz, input logic [7:0] sd, input string tag);
    int ecode, erc, edc, ewr;
    bit eovf, got;
    logic [1:0] a_code;
    logic [3:0] a_rc;
    logic [CW-1:0] a_dc;
    logic a_ovf;
    erc = 0; edc = 0; ewr = 0; eovf = 0;
    if (d >= TMO || (!dn && !dc)) ecode = 1;
    else if (dc) ecode = 3;
    else if (|fl[1:0]) ecode = 1;
    else if (|fl[5:2]) ecode = 2;
    else if (cnt == 0) ecode = 2;
    else begin
      ecode = 0; edc = int'(cnt) - 1; erc = rc;
      if (rc == 0 && edc != 0) begin
        if (edc > int'(bsz)) eovf = 1; else ewr = edc;
      end
    end
    @(negedge clk);
    clr = 1; rx_flags = fl; rx_count = cnt; buf_size = bsz; seed = sd; rcode = rc;
    start = 1; byte_vld = 1;
    @(negedge clk);
    clr = 0; start = 0;
    got = 0;
    for (int k = 0; k < 300; k++) begin
      if (res_vld) begin got = 1; break; end
      if (k == d) begin rx_done = dn; hpd_lost = dc; end
      @(negedge clk);
    end
    a_code = res_code; a_rc = reply_code; a_dc = data_cnt; a_ovf = overflow;
    rx_done = 0; hpd_lost = 0; byte_vld = 0;
    chk(got, "R11 strobe seen", got, 1);
    @(negedge clk);
    chk(!res_vld, "R11 strobe one cycle", res_vld, 0);
    chk(a_code == ecode, tag, a_code, ecode);
    chk(res_code == a_code, "R11 result held", res_code, a_code);
    chk(a_rc == erc, "R7 reply code", a_rc, erc);
    chk(a_dc == edc, "R6 data count", a_dc, edc);
    chk(a_ovf == eovf, "R9 overflow", a_ovf, eovf);
    chk(wcnt == ewr, "R8 write count", wcnt, ewr);
    for (int i = 0; i < ewr; i++)
      chk(mem[i] == pat(sd, 8'(i + 1)), "R8 write data", mem[i], pat(sd, 8'(i + 1)));
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!res_vld && !buf_we && !byte_rdy && res_code == 0 && reply_code == 0 &&
        data_cnt == 0 && !overflow, "R1 reset state", res_vld, 0);
    rst_n = 1;
    @(negedge clk);
    // R3 R4 R5: every flag pattern
    for (int f = 0; f < 128; f++)
      run(7'(f), 1, 0, 1, 5'd4, 4'd0, 5'd10, 8'(f * 7), f[6] ? "R5 flag priority" : "R3 R4 flag priority");
    // R2: disconnect beats everything
    for (int f = 0; f < 4; f++)
      for (int d = 0; d < 4; d++) begin
        run(7'(f * 41), 1, 1, d, 5'd3, 4'd0, 5'd8, 8'h5a, "R2 disconnect");
        run(7'(f * 41), 0, 1, d, 5'd3, 4'd0, 5'd8, 8'h33, "R2 disconnect alone");
      end
    // R10: watchdog around its limit
    for (int d = 0; d <= TMO + 2; d++)
      run(7'd0, 1, 0, d, 5'd2, 4'd0, 5'd4, 8'(d), "R10 watchdog");
    run(7'd0, 0, 0, 0, 5'd2, 4'd0, 5'd4, 8'h11, "R10 no done");
    // R6 R7 R8 R9: counts, capacities and reply codes
    for (int c = 0; c < 32; c++)
      for (int b = 0; b < 4; b++)
        for (int r = 0; r < 4; r++)
          run(7'd0, 1, 0, 2, 5'(c), (r == 0) ? 4'd0 : 4'(r * r + 1),
              (b == 0) ? 5'd0 : (b == 1) ? 5'd3 : (b == 2) ? 5'd16 : 5'd31,
              8'(c * 13 + b), "R6 count result");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule